// File: doc/BRIEF.md
# Pseudo-SRAM Mode Register Unlock Sequencer

This block sits beside the array of an asynchronous pseudo-SRAM-style memory and watches its bus: the main chip enable, output enable, write enable, address and 16-bit data. A bus cycle counts as complete when its strobe rises while the chip enable is low. Output enable marks a read and write enable marks a write. Four completed cycles at the top address, in the order read, read, write, write, form an unlock pattern. The first of the two writes must carry the key word 0000h. The data of the final write is then stored in an internal mode register.

The mode register drives a 3-bit page-length code (data bits 2:0) and a sleep enable bit (data bit 4 by default). The sleep request is raised only while the secondary chip enable is low and the sleep bit is set. The register has no storage location of its own in the array. The block therefore raises a write-suppress signal during the key write and the final write, so the array word at the top address is left untouched. Any completed cycle that breaks the pattern sends the sequencer back to idle and leaves the register unchanged. After reset the register reads zero, and a flag shows whether it has been loaded since then.

All bus inputs are assumed to be already synchronised to `clk`. Each bus level is assumed to stay stable for at least one clock edge before its strobe rises.

Top module: `psram_mr_unlock`

## Requirements
- R1: After reset, page_len is 0, sleep_en is 0, sleep_req is 0, programmed is 0 and wr_suppress is 0.
- R2: Four completed cycles at the top address (all address bits 1), in the order read, read, write with data 0000h, write, load the data of the last write into the mode register. Completion is the rising strobe edge sampled with ce_n low. In the first clock after the edge at which the last write completes, page_len equals data bits 2:0, sleep_en equals data bit 4, and programmed is 1. programmed stays 1 until reset.
- R3: A completed cycle at any address other than the top one, at any step of the pattern, returns the sequencer to idle without changing page_len or sleep_en.
- R4: A completed cycle of the wrong type for its step returns the sequencer to idle without changing the register. A write where a read is due is such a cycle, and so is a read where a write is due (for example a third read after two reads).
- R5: A third cycle whose write data is not 0000h returns the sequencer to idle without changing the register.
- R6: wr_suppress is 1 while the key write (ce_n low, we_n low, top address, data 0000h, after two pattern reads) or the final write of the pattern is in progress. It is 0 during ordinary writes, including a write to the top address from idle.
- R7: sleep_req is a registered output. One clock after a cycle in which ce2 is low and sleep_en is 1, it is 1. Otherwise it is 0.
- R8: A strobe that rises while ce_n is high is not a bus cycle. It neither advances nor aborts the pattern.
- R9: A strobe held low over many clocks counts as a single cycle.
- R10: A later complete pattern overwrites the mode register with the new final-write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Main chip enable, active low |
| ce2 | input | 1 | Secondary chip enable; low requests sleep |
| oe_n | input | 1 | Output enable, active low; its rise ends a read |
| we_n | input | 1 | Write enable, active low; its rise ends a write |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data seen on the bus |
| page_len | output | 3 | Page-length code from mode bits 2:0 |
| sleep_en | output | 1 | Sleep enable bit of the mode register |
| sleep_req | output | 1 | Registered request to enter sleep |
| programmed | output | 1 | Mode register loaded since reset |
| wr_suppress | output | 1 | Tells the array to ignore the current write |

## Verification
Loading the register and making the sleep decision can fall in the same clock. The last write of a pattern can complete while ce2 is already low, with the new data changing the sleep bit. The bench provokes this with ce2 held low while it reprograms the sleep bit from 1 to 0 and from 0 to 1. It expects sleep_req to show the old bit at the first sample after the load and the new bit one clock later. The bench also sweeps every page code together with both sleep values, and corrupts each of the four steps by address and by cycle type.

// File: rtl/psram_mr_pkg.sv
// Shared types for the mode-register unlock sequencer.
// Assumes nothing beyond a four-step pattern.
package psram_mr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no pattern step seen
        ST_RD1  = 2'd1,   // one top-address read seen
        ST_RD2  = 2'd2,   // two top-address reads seen
        ST_KEY  = 2'd3    // key write seen, final write due
    } seq_st_t;
endpackage

// File: rtl/mr_bus_cycle_det.sv
// Turns asynchronous bus strobes into one-clock cycle-complete pulses.
// A cycle completes when a strobe rises while the chip enable was low.
// It also keeps the address and data sampled while the strobe was low.
// Assumes inputs are already synchronised and are stable for at least
// one clock before the strobe rises.
module mr_bus_cycle_det #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_done,
    output logic              wr_done,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_dq
);
    logic oe_q, we_q, ce_q;

    // Purpose: hold the previous strobe levels and the bus values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q     <= 1'b1;
            we_q     <= 1'b1;
            ce_q     <= 1'b1;
            cap_addr <= '0;
            cap_dq   <= '0;
        end else begin
            oe_q     <= oe_n;
            we_q     <= we_n;
            ce_q     <= ce_n;
            cap_addr <= addr;
            cap_dq   <= dq_in;
        end
    end

    // Purpose: detect each strobe's rising edge inside an enabled cycle.
    always_comb begin
        rd_done = oe_n && !oe_q && !ce_q && we_q;
        wr_done = we_n && !we_q && !ce_q;
    end
endmodule

// File: rtl/mr_seq_fsm.sv
// Tracks the read, read, key-write, write pattern at the top address.
// Any completed cycle that breaks the pattern sends the FSM to idle.
// It gives a load pulse on the final write, and drives the live
// write-suppress from the present bus levels so that it covers the
// whole write strobe.
module mr_seq_fsm
    import psram_mr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_done,
    input  logic wr_done,
    input  logic cap_top,
    input  logic cap_key,
    input  logic live_wr,
    input  logic live_top,
    input  logic live_key,
    output logic load,
    output logic wr_suppress
);
    seq_st_t st_q, st_d;

    // Purpose: choose the next step from the completed cycle.
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (rd_done || wr_done) begin
            st_d = ST_IDLE;
            unique case (st_q)
                ST_IDLE: if (rd_done && cap_top) st_d = ST_RD1;
                ST_RD1:  if (rd_done && cap_top) st_d = ST_RD2;
                ST_RD2:  if (wr_done && cap_top && cap_key) st_d = ST_KEY;
                ST_KEY:  load = wr_done && cap_top;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: hold the pattern step.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: mask the array write during the key and final writes.
    always_comb begin
        wr_suppress = live_wr && live_top &&
                      ((st_q == ST_RD2 && live_key) || st_q == ST_KEY);
    end
endmodule

// File: rtl/mr_mode_store.sv
// Holds the mode register, the programmed flag and the registered
// sleep request. The register resets to zero, so sleep stays off
// until the register is written.
module mr_mode_store #(
    parameter int DATA_W    = 16,
    parameter int PAGE_W    = 3,
    parameter int SLEEP_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ce2,
    output logic [PAGE_W-1:0] page_len,
    output logic              sleep_en,
    output logic              sleep_req,
    output logic              programmed
);
    logic [DATA_W-1:0] mode_q;

    // Purpose: load the register and set the programmed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            programmed <= 1'b0;
        end else if (load) begin
            mode_q     <= din;
            programmed <= 1'b1;
        end
    end

    // Purpose: register the sleep entry condition.
    always_ff @(posedge clk) begin
        if (!rst_n) sleep_req <= 1'b0;
        else        sleep_req <= mode_q[SLEEP_BIT] && !ce2;
    end

    // Purpose: break out the register fields.
    always_comb begin
        page_len = mode_q[PAGE_W-1:0];
        sleep_en = mode_q[SLEEP_BIT];
    end
endmodule

// File: rtl/psram_mr_unlock.sv
// Top of the mode-register unlock sequencer. Wires cycle detection,
// pattern tracking and the mode store. The top address is all ones.
module psram_mr_unlock #(
    parameter int ADDR_W    = 21,
    parameter int PAGE_W    = 3,
    parameter int SLEEP_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [PAGE_W-1:0] page_len,
    output logic              sleep_en,
    output logic              sleep_req,
    output logic              programmed,
    output logic              wr_suppress
);
    localparam int DATA_W = 16;
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    logic              rd_done, wr_done, load;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_dq;

    mr_bus_cycle_det #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_det (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .rd_done(rd_done), .wr_done(wr_done),
        .cap_addr(cap_addr), .cap_dq(cap_dq)
    );

    mr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .wr_done(wr_done),
        .cap_top(cap_addr == TOP_ADDR), .cap_key(cap_dq == '0),
        .live_wr(!ce_n && !we_n), .live_top(addr == TOP_ADDR),
        .live_key(dq_in == '0), .load(load), .wr_suppress(wr_suppress)
    );

    mr_mode_store #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .SLEEP_BIT(SLEEP_BIT)) u_store (
        .clk(clk), .rst_n(rst_n), .load(load), .din(cap_dq), .ce2(ce2),
        .page_len(page_len), .sleep_en(sleep_en), .sleep_req(sleep_req),
        .programmed(programmed)
    );
endmodule

// File: rtl/psram_mr_unlock_chk.sv
// Checker for the unlock sequencer, observing only its ports.
module psram_mr_unlock_chk #(
    parameter int ADDR_W = 21,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              ce2,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [PAGE_W-1:0] page_len,
    input logic              sleep_en,
    input logic              sleep_req,
    input logic              programmed,
    input logic              wr_suppress
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    // R6: suppress only while a top-address write is on the bus
    p_suppress_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (!ce_n && !we_n && addr == TOP));

    // R2: a register change follows a top-address write strobe
    p_load_at_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(page_len) || !$stable(sleep_en)) |->
        ($past(addr, 2) == TOP && !$past(we_n, 2) && programmed));

    // R2: programmed flag never drops outside reset
    p_programmed_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(programmed));

    // R7: sleep request needs ce2 low and the sleep bit one clock earlier
    p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> ($past(!ce2) && $past(sleep_en)));
endmodule

bind psram_mr_unlock psram_mr_unlock_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .we_n(we_n),
    .addr(addr), .page_len(page_len), .sleep_en(sleep_en),
    .sleep_req(sleep_req), .programmed(programmed), .wr_suppress(wr_suppress)
);

// File: tb/psram_mr_unlock_tb.sv
module psram_mr_unlock_tb;
    localparam int ADDR_W = 21;
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, ce2 = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [2:0] page_len;
    logic sleep_en, sleep_req, programmed, wr_suppress;
    int checks = 0, errors = 0;
    int exp_page = 0, exp_sleep = 0;
    logic sup_seen;

    always #10 clk = ~clk;

    psram_mr_unlock #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2(ce2), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .page_len(page_len),
        .sleep_en(sleep_en), .sleep_req(sleep_req), .programmed(programmed),
        .wr_suppress(wr_suppress)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One bus cycle: strobe low for 'hold' clocks, then raised.
    // Returns at the first negedge after the completing clock edge.
    task automatic bus(input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [15:0] d, input int hold, input bit en);
        @(negedge clk);
        ce_n = !en; addr = a; dq_in = d;
        if (wr) we_n = 1'b0; else oe_n = 1'b0;
        sup_seen = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            sup_seen = sup_seen | wr_suppress;
        end
        oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic check_reg(input string tag);
        chk({tag, " page_len"}, page_len, exp_page);
        chk({tag, " sleep_en"}, sleep_en, exp_sleep);
    endtask

    task automatic prog(input logic [15:0] d);
        bus(0, TOP, 16'hAAAA, 1, 1);
        bus(0, TOP, 16'h5555, 1, 1);
        bus(1, TOP, 16'h0000, 1, 1);
        chk("R6 key write suppressed", sup_seen, 1);
        bus(1, TOP, d, 1, 1);
        chk("R6 final write suppressed", sup_seen, 1);
        exp_page = d[2:0]; exp_sleep = d[4];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 page_len", page_len, 0);
        chk("R1 sleep_en", sleep_en, 0);
        chk("R1 sleep_req", sleep_req, 0);
        chk("R1 programmed", programmed, 0);
        chk("R1 wr_suppress", wr_suppress, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: ordinary writes are not suppressed
        bus(1, TOP, 16'h0000, 1, 1);
        chk("R6 idle top write", sup_seen, 0);
        bus(1, 21'h00_1234, 16'h0000, 1, 1);
        chk("R6 low address write", sup_seen, 0);
        chk("R2 not yet programmed", programmed, 0);

        // R2/R7/R10: sweep page codes and the sleep bit
        for (int v = 0; v < 16; v++) begin
            logic [15:0] d;
            d = 16'hC0E0 ^ {8'h00, 3'b000, v[3], 1'b0, v[2:0]} ^ 16'h00E0;
            d[4] = v[3];
            prog(d);
            check_reg("R2 R10 load");
            chk("R2 programmed", programmed, 1);
            ce2 = 1'b0;
            @(negedge clk); @(negedge clk);
            chk("R7 sleep with ce2 low", sleep_req, exp_sleep);
            ce2 = 1'b1;
            @(negedge clk); @(negedge clk);
            chk("R7 no sleep with ce2 high", sleep_req, 0);
        end

        // Load and sleep decision in the same clock, ce2 held low
        prog(16'h0013);
        ce2 = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R7 sleep before reload", sleep_req, 1);
        prog(16'h0002);
        chk("R7 old bit at load", sleep_req, 1);
        @(negedge clk);
        chk("R7 new bit next clock", sleep_req, 0);
        prog(16'h0015);
        chk("R7 old bit at load", sleep_req, 0);
        @(negedge clk);
        chk("R7 new bit next clock", sleep_req, 1);
        ce2 = 1'b1;
        prog(16'h0006);

        // R3/R4: corrupt each step by address and by type
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < k; s++)
                    bus(s >= 2, TOP, 16'h0000, 1, 1);
                if (m == 0)
                    bus(k >= 2, TOP ^ (21'h1 << k), (k == 3) ? 16'h0001 : 16'h0000, 1, 1);
                else
                    bus(k < 2, TOP, 16'h0000, 1, 1);
                @(negedge clk);
                check_reg(m == 0 ? "R3 wrong address" : "R4 wrong type");
                prog(16'h0001 + k[15:0] + m[15:0]);
                check_reg("R3 R4 recovery");
            end
        end

        // R4: three reads then two writes do not load
        bus(0, TOP, 0, 1, 1); bus(0, TOP, 0, 1, 1); bus(0, TOP, 0, 1, 1);
        bus(1, TOP, 0, 1, 1);
        chk("R6 no suppress after abort", sup_seen, 0);
        bus(1, TOP, 16'h0017, 1, 1);
        check_reg("R4 extra read");

        // R5: nonzero key aborts
        for (int b = 0; b < 16; b += 5) begin
            bus(0, TOP, 0, 1, 1); bus(0, TOP, 0, 1, 1);
            bus(1, TOP, 16'h1 << b, 1, 1);
            chk("R5 bad key not suppressed", sup_seen, 0);
            bus(1, TOP, 16'h0014, 1, 1);
            check_reg("R5 bad key");
        end

        // R8: strobes with ce_n high are ignored
        bus(0, TOP, 0, 1, 1); bus(0, TOP, 0, 1, 1);
        bus(0, 21'h0, 0, 1, 0);
        bus(1, 21'h0, 16'h1111, 1, 0);
        bus(1, TOP, 0, 1, 1); bus(1, TOP, 16'h0015, 1, 1);
        exp_page = 5; exp_sleep = 1;
        check_reg("R8 disabled strobes ignored");

        // R9: a long read counts once
        bus(0, TOP, 0, 6, 1);
        bus(1, TOP, 0, 1, 1); bus(1, TOP, 16'h0003, 1, 1);
        check_reg("R9 long read once");
        bus(0, TOP, 0, 6, 1); bus(0, TOP, 0, 1, 1);
        bus(1, TOP, 0, 4, 1); bus(1, TOP, 16'h0002, 5, 1);
        exp_page = 2; exp_sleep = 0;
        check_reg("R9 long strobes load");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule